// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block judges one memory access against one code or data segment descriptor. A request carries four things: a 64-bit descriptor, a 32-bit offset, an access kind (read, write or execute) and the current privilege level. The block unpacks the base, the limit and the control flags from the descriptor. It then tests the descriptor for well-formedness, presence, access type, privilege and offset range.

The result is either the linear address (base plus offset) or a single fault code chosen by a fixed priority. On success the block also returns the descriptor with its accessed flag set. It raises a write-back strobe when that flag was previously clear, so that the surrounding logic can store the updated descriptor.

Requests and responses each use a valid/ready handshake. The result is registered and appears in the cycle after a request is accepted. A result is held until the consumer takes it.

Top module: `seg_access_chk`

## Requirements
- R1: The base is bits 39:16 (base[23:0]) joined with bits 63:56 (base[31:24]), and the 20-bit limit is bits 15:0 joined with bits 51:48; a successful access returns linear = base + offset modulo 2^32.
- R2: With granularity (bit 55) clear, an expand-up segment accepts offsets 0 through the limit inclusive, and the first offset above the limit raises the limit fault (code 5).
- R3: With granularity set, the effective limit is {limit, 12'hFFF}: offset {limit,12'hFFF} passes and the next offset faults with code 5.
- R4: A data segment (bit 43 clear) with expand-down (bit 42) set accepts offsets from effective limit + 1 up to the maximum offset, and rejects offsets at or below the effective limit with code 5. In a code segment, bit 42 means conforming and does not change the range.
- R5: For a data segment, the maximum offset is 0xFFFFFFFF when the big flag (bit 54) is set and 0x0000FFFF when it is clear; an offset above 0xFFFF then faults with code 5 in either direction.
- R6: A descriptor whose present bit (bit 47) is clear raises the not-present fault (code 2).
- R7: Access kinds are encoded read=0, write=1, execute=2, and kind 3 is invalid. A type fault (code 3) is raised for each of the following:
  - a write to code;
  - an execute of data;
  - a read of code whose readable bit (bit 41) is clear;
  - a write to data whose writable bit (bit 41) is clear;
  - kind 3.
- R8: A descriptor with the segment-class bit (bit 44) clear, or with both the long bit (bit 53) and the default-size bit (bit 54) set, raises the descriptor fault (code 1).
- R9: The descriptor privilege level (bits 46:45) and the current level (CPL) are compared only when the segment is not conforming. For data, and for code with bit 42 clear, a CPL greater than the descriptor level raises the privilege fault (code 4). Conforming code (bit 43 and bit 42 set) skips the privilege check.
- R10: When several faults apply, the reported code follows this priority, highest first: descriptor (1), not-present (2), type (3), privilege (4), limit (5). Code 0 means success.
- R11: On success the returned descriptor equals the input with bit 40 set, and the write-back strobe is high exactly when bit 40 was clear; on a fault the descriptor is returned unchanged and the strobe stays low.
- R12: A result appears the cycle after acceptance and is held stable while the response is not taken. On a fault the linear address is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_desc | input | 64 | Segment descriptor |
| req_offset | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 3 | Fault code, 0 for success |
| rsp_linear | output | 32 | Linear address, zero on fault |
| rsp_desc | output | 64 | Descriptor with accessed bit updated |
| rsp_wb | output | 1 | Descriptor changed and should be stored |

## Verification
The assertions assume that the request inputs hold steady only for the cycle in which the handshake completes. They also assume that the consumer drives rsp_ready cleanly. The hold property therefore constrains only the registered result and never the request side.

The stimulus builds each descriptor from named fields, so every flag combination that is used is deliberate. The offsets sit on and next to each effective limit and each maximum offset. One stall window keeps rsp_ready low while a result is pending, which exercises both the response hold and the request back-pressure.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int DESC_W = 64;
  localparam int ADDR_W = 32;
  localparam int ACC_BIT = 40;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_DESC  = 3'd1,
    FLT_NP    = 3'd2,
    FLT_TYPE  = 3'd3,
    FLT_PRIV  = 3'd4,
    FLT_LIMIT = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } kind_e;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] lim;
    logic        gran;
    logic        big;
    logic        lng;
    logic        pres;
    logic [1:0]  dpl;
    logic        cls;
    logic        code;
    logic        dirc;   // expand-down for data, conforming for code
    logic        perm;   // writable for data, readable for code
    logic        acc;
  } seg_fields_t;

  function automatic seg_fields_t unpack_desc(input logic [DESC_W-1:0] d);
    seg_fields_t f;
    f.base = {d[63:56], d[39:16]};
    f.lim  = {d[51:48], d[15:0]};
    f.gran = d[55];
    f.big  = d[54];
    f.lng  = d[53];
    f.pres = d[47];
    f.dpl  = d[46:45];
    f.cls  = d[44];
    f.code = d[43];
    f.dirc = d[42];
    f.perm = d[41];
    f.acc  = d[ACC_BIT];
    return f;
  endfunction
endpackage

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int ADDR_W    = 32,
  parameter int LIM_W     = 20,
  parameter int PAGE_BITS = 12,
  parameter int SMALL_W   = 16
) (
  input  logic [LIM_W-1:0]  lim,
  input  logic              gran,
  input  logic              big,
  input  logic              code,
  input  logic              dirc,
  input  logic [ADDR_W-1:0] offset,
  output logic              lim_bad
);
  localparam logic [ADDR_W-1:0] PAGE_FILL = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] SMALL_MAX = ADDR_W'((64'd1 << SMALL_W) - 64'd1);

  logic [ADDR_W-1:0] eff_lim;
  logic [ADDR_W-1:0] max_off;
  logic              down;

  always_comb begin
    eff_lim = gran ? ((ADDR_W'(lim) << PAGE_BITS) | PAGE_FILL) : ADDR_W'(lim);
    max_off = (!code && !big) ? SMALL_MAX : {ADDR_W{1'b1}};
    down    = !code && dirc;
    if (offset > max_off)
      lim_bad = 1'b1;
    else if (down)
      lim_bad = (offset <= eff_lim);
    else
      lim_bad = (offset > eff_lim);
  end

  // R5: small data segments never admit offsets beyond the 16-bit range
  always_comb begin
    if (!code && !big && offset > SMALL_MAX)
      p_small_cap_r5: assert (lim_bad);
  end
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import seg_pkg::*;
(
  input  logic       code,
  input  logic       dirc,
  input  logic       perm,
  input  logic [1:0] kind,
  input  logic [1:0] dpl,
  input  logic [1:0] cpl,
  output logic       type_bad,
  output logic       priv_bad
);
  always_comb begin
    unique case (kind)
      ACC_READ:  type_bad = code && !perm;
      ACC_WRITE: type_bad = code || !perm;
      ACC_EXEC:  type_bad = !code;
      default:   type_bad = 1'b1;
    endcase
    if (code && dirc)
      priv_bad = 1'b0;
    else
      priv_bad = (cpl > dpl);
  end

  // R7: writing into a code segment is always refused
  always_comb begin
    if (code && kind == ACC_WRITE)
      p_no_code_write_r7: assert (type_bad);
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import seg_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int SMALL_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_cpl,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_linear,
  output logic [DESC_W-1:0] rsp_desc,
  output logic              rsp_wb
);
  localparam logic [DESC_W-1:0] ACC_MASK = DESC_W'(1) << ACC_BIT;

  seg_fields_t f;
  logic        lim_bad, type_bad, priv_bad, accept, ok;
  fault_e      fault_c;

  assign f         = unpack_desc(req_desc);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  seg_limit_chk #(
    .ADDR_W(ADDR_W), .LIM_W(20), .PAGE_BITS(PAGE_BITS), .SMALL_W(SMALL_W)
  ) lim_i (
    .lim(f.lim), .gran(f.gran), .big(f.big), .code(f.code), .dirc(f.dirc),
    .offset(req_offset), .lim_bad(lim_bad)
  );

  seg_rights_chk rights_i (
    .code(f.code), .dirc(f.dirc), .perm(f.perm), .kind(req_kind),
    .dpl(f.dpl), .cpl(req_cpl), .type_bad(type_bad), .priv_bad(priv_bad)
  );

  always_comb begin
    if (!f.cls || (f.lng && f.big)) fault_c = FLT_DESC;
    else if (!f.pres)               fault_c = FLT_NP;
    else if (type_bad)              fault_c = FLT_TYPE;
    else if (priv_bad)              fault_c = FLT_PRIV;
    else if (lim_bad)               fault_c = FLT_LIMIT;
    else                            fault_c = FLT_NONE;
    ok = (fault_c == FLT_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 3'd0;
      rsp_linear <= '0;
      rsp_desc   <= '0;
      rsp_wb     <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_fault  <= fault_c;
      rsp_linear <= ok ? f.base + req_offset : '0;
      rsp_desc   <= ok ? (req_desc | ACC_MASK) : req_desc;
      rsp_wb     <= ok && !f.acc;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
      rsp_wb     <= 1'b0;
    end
  end

  // R12: a faulting result never carries an address
  p_fault_no_addr_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_linear == '0));

  // R12: a result not taken stays put
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)
      && $stable(rsp_linear) && $stable(rsp_desc) && $stable(rsp_wb)));

  // R11: success always leaves the accessed flag set
  p_acc_set_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 3'd0) |-> rsp_desc[ACC_BIT]);

  // R11: strobe only accompanies a valid successful result
  p_wb_ok_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_wb |-> (rsp_valid && rsp_fault == 3'd0));

  // R10: fault code stays within the defined set
  p_code_range_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault <= 3'd5));
endmodule

// File: tb/seg_access_chk_tb.sv
module seg_access_chk_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_desc = '0;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_cpl = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_linear;
  logic [63:0] rsp_desc;
  logic        rsp_wb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  fault;
    logic [31:0] lin;
    logic [63:0] desc;
    logic        wb;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  seg_access_chk dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_desc(req_desc), .req_offset(req_offset), .req_kind(req_kind),
    .req_cpl(req_cpl), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_linear(rsp_linear), .rsp_desc(rsp_desc),
    .rsp_wb(rsp_wb)
  );

  task automatic chk(input bit cond, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
      input bit g, input bit b, input bit l, input bit p, input logic [1:0] dpl,
      input bit s, input logic [3:0] typ);
    logic [63:0] d;
    d = '0;
    d[15:0] = lim[15:0];  d[39:16] = base[23:0]; d[43:40] = typ;
    d[44] = s; d[46:45] = dpl; d[47] = p; d[51:48] = lim[19:16];
    d[53] = l; d[54] = b; d[55] = g; d[63:56] = base[31:24];
    return d;
  endfunction

  // Reference computed from the requirement text
  function automatic exp_t model(input logic [63:0] d, input logic [31:0] off,
                                 input logic [1:0] kind, input logic [1:0] cpl);
    exp_t e;
    logic [31:0] base, eff, top;
    logic [19:0] lim;
    bit is_code, tbad, pbad, lbad;
    base = {d[63:56], d[39:16]};
    lim  = {d[51:48], d[15:0]};
    eff  = d[55] ? {lim, 12'hFFF} : {12'h000, lim};
    is_code = d[43];
    top  = (!is_code && !d[54]) ? 32'h0000FFFF : 32'hFFFFFFFF;
    if (off > top) lbad = 1;
    else if (!is_code && d[42]) lbad = !(off >= eff + 32'd1 && eff != 32'hFFFFFFFF);
    else lbad = off > eff;
    case (kind)
      2'd0: tbad = is_code && !d[41];
      2'd1: tbad = is_code || !d[41];
      2'd2: tbad = !is_code;
      default: tbad = 1;
    endcase
    pbad = (is_code && d[42]) ? 0 : (cpl > d[46:45]);
    if (!d[44] || (d[53] && d[54])) e.fault = 3'd1;
    else if (!d[47]) e.fault = 3'd2;
    else if (tbad)   e.fault = 3'd3;
    else if (pbad)   e.fault = 3'd4;
    else if (lbad)   e.fault = 3'd5;
    else             e.fault = 3'd0;
    e.lin  = (e.fault == 0) ? base + off : 32'd0;
    e.desc = (e.fault == 0) ? (d | (64'd1 << 40)) : d;
    e.wb   = (e.fault == 0) && !d[40];
    return e;
  endfunction

  task automatic send(input logic [63:0] d, input logic [31:0] off,
                      input logic [1:0] kind, input logic [1:0] cpl, input string tag);
    exp_t e;
    e = model(d, off, kind, cpl);
    e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_desc = d; req_offset = off; req_kind = kind; req_cpl = cpl;
    forever begin
      #5;
      if (req_ready) begin
        sb.push_back(e);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Monitor: compares results as they are taken
  always @(negedge clk) begin
    #5;
    if (!rst && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(0, "R12 unexpected result", 64'(rsp_fault), 64'hx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_fault == e.fault, {e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
        chk(rsp_linear == e.lin, {e.tag, " linear"}, 64'(rsp_linear), 64'(e.lin));
        chk(rsp_desc == e.desc, {e.tag, " desc"}, rsp_desc, e.desc);
        chk(rsp_wb == e.wb, {e.tag, " wb"}, 64'(rsp_wb), 64'(e.wb));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #5;
    chk(rsp_valid == 0, "R12 reset rsp_valid", 64'(rsp_valid), 0);
    chk(req_ready == 1, "R12 reset req_ready", 64'(req_ready), 1);

    // R1 base assembly and sum; R2 byte limit boundaries
    d = mk(32'h12345000, 20'h000FF, 0, 1, 0, 1, 2'd0, 1, 4'b0010);
    send(d, 32'h10, 2'd0, 2'd0, "R1 read base+off");
    #5 chk(rsp_valid == 1, "R12 one-cycle latency", 64'(rsp_valid), 1);
    send(mk(32'hA5000000, 20'h0, 0, 1, 0, 1, 2'd3, 1, 4'b0010), 32'h0, 2'd1, 2'd3, "R1 top base byte");
    send(d, 32'hFF, 2'd1, 2'd0, "R2 offset at limit");
    send(d, 32'h100, 2'd0, 2'd0, "R2 offset past limit");

    // R3 page granularity
    d = mk(32'h00100000, 20'h00002, 1, 1, 0, 1, 2'd0, 1, 4'b0010);
    send(d, 32'h2FFF, 2'd0, 2'd0, "R3 page limit top");
    send(d, 32'h3000, 2'd0, 2'd0, "R3 page limit past");

    // R4 expand-down
    d = mk(32'h0, 20'h00FFF, 0, 1, 0, 1, 2'd0, 1, 4'b0110);
    send(d, 32'h0FFF, 2'd0, 2'd0, "R4 down at limit");
    send(d, 32'h1000, 2'd0, 2'd0, "R4 down above limit");
    send(d, 32'hFFFFFFFF, 2'd1, 2'd0, "R4 down max offset");
    send(mk(32'h0, 20'h00005, 0, 1, 0, 1, 2'd0, 1, 4'b1110), 32'h6, 2'd2, 2'd0, "R4 conforming code range");

    // R5 small data segment cap
    d = mk(32'h0, 20'hFFFFF, 0, 0, 0, 1, 2'd0, 1, 4'b0010);
    send(d, 32'hFFFF, 2'd0, 2'd0, "R5 small max");
    send(d, 32'h10000, 2'd0, 2'd0, "R5 small over");
    send(mk(32'h0, 20'h00FFF, 0, 0, 0, 1, 2'd0, 1, 4'b0110), 32'h10000, 2'd0, 2'd0, "R5 small down over");
    send(mk(32'h0, 20'h00FFF, 0, 0, 0, 1, 2'd0, 1, 4'b0110), 32'hFFFF, 2'd0, 2'd0, "R5 small down max");

    // R6 not present
    send(mk(32'h0, 20'hFFFFF, 0, 1, 0, 0, 2'd0, 1, 4'b0010), 32'h0, 2'd0, 2'd0, "R6 not present");

    // R7 type rules
    d = mk(32'h4000, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b1010);
    send(d, 32'h4, 2'd1, 2'd0, "R7 write code");
    send(d, 32'h4, 2'd2, 2'd0, "R7 exec code ok");
    send(d, 32'h4, 2'd0, 2'd0, "R7 read readable code");
    send(mk(32'h4000, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b1000), 32'h4, 2'd0, 2'd0, "R7 read exec-only code");
    send(mk(32'h4000, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0000), 32'h4, 2'd1, 2'd0, "R7 write read-only data");
    send(mk(32'h4000, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0000), 32'h4, 2'd2, 2'd0, "R7 exec data");
    send(mk(32'h4000, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0010), 32'h4, 2'd3, 2'd0, "R7 bad kind");

    // R8 malformed and system
    send(mk(32'h0, 20'hFFFFF, 0, 1, 1, 1, 2'd0, 1, 4'b1010), 32'h0, 2'd2, 2'd0, "R8 long plus default");
    send(mk(32'h0, 20'hFFFFF, 0, 0, 1, 1, 2'd0, 1, 4'b1010), 32'h0, 2'd2, 2'd0, "R8 long alone ok");
    send(mk(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 0, 4'b0010), 32'h0, 2'd0, 2'd0, "R8 system segment");

    // R9 privilege
    send(mk(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0010), 32'h0, 2'd0, 2'd3, "R9 data cpl above dpl");
    send(mk(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd2, 1, 4'b0010), 32'h0, 2'd0, 2'd2, "R9 data cpl equal dpl");
    send(mk(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b1010), 32'h0, 2'd2, 2'd3, "R9 nonconforming code");
    send(mk(32'h0, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b1110), 32'h0, 2'd2, 2'd3, "R9 conforming code");

    // R10 priority
    send(mk(32'h0, 20'h0, 0, 1, 0, 0, 2'd0, 0, 4'b0010), 32'h5, 2'd2, 2'd3, "R10 desc over np");
    send(mk(32'h0, 20'h0, 0, 1, 0, 0, 2'd0, 1, 4'b0010), 32'h5, 2'd2, 2'd3, "R10 np over type");
    send(mk(32'h0, 20'h0, 0, 1, 0, 1, 2'd0, 1, 4'b0010), 32'h5, 2'd2, 2'd3, "R10 type over priv");
    send(mk(32'h0, 20'h0, 0, 1, 0, 1, 2'd0, 1, 4'b0010), 32'h5, 2'd0, 2'd3, "R10 priv over limit");

    // R11 accessed already set
    send(mk(32'h800, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0011), 32'h8, 2'd0, 2'd0, "R11 accessed already set");
    send(mk(32'h800, 20'h0, 0, 1, 0, 1, 2'd0, 1, 4'b0011), 32'h8, 2'd0, 2'd0, "R11 fault keeps desc");

    // R12 stall: result held while not taken
    @(negedge clk); rsp_ready = 1'b0;
    send(mk(32'h1000, 20'hFFFFF, 0, 1, 0, 1, 2'd0, 1, 4'b0010), 32'h20, 2'd0, 2'd0, "R12 stalled result");
    #5 held = rsp_linear;
    repeat (3) @(negedge clk);
    #5;
    chk(rsp_valid == 1, "R12 held valid", 64'(rsp_valid), 1);
    chk(rsp_linear == held, "R12 held linear", 64'(rsp_linear), 64'(held));
    chk(req_ready == 0, "R12 back-pressure", 64'(req_ready), 0);
    @(negedge clk); rsp_ready = 1'b1;

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R12 all results seen", 64'(sb.size()), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule